// File: doc/BRIEF.md
# Boundary-Splitting Descriptor Table Builder

This block turns a stream of memory buffer segments, each an address and a byte length, into the table of four-word descriptors that a scatter-gather DMA engine walks. No descriptor may span a 64 KiB address boundary, so a segment is cut into as many descriptors as needed: each piece runs from the current address to the next 64 KiB boundary, or to the end of the segment if that comes first. Every descriptor goes out as four 32-bit words on a write port addressed by word index into the table memory.

A list ends on a segment flagged as last, or on a zero-length segment. When a list ends with at least one descriptor, the builder writes the length word of the final descriptor a second time with its end-of-list flag set. It then pulses `done` with the entry count. If a list needs more descriptors than the table holds, the builder writes nothing further. It consumes the rest of the list and reports overflow with a count of zero, so that the requester can move the data by programmed I/O instead. Segments come in on a valid/ready handshake, and words go out on a valid/ready handshake.

Top module: `dtb_builder`

## Requirements
- R1: Each descriptor length equals 0x10000 minus the low 16 bits of the current address, or the remaining segment length if that is smaller. No descriptor crosses a 64 KiB boundary.
- R2: After each descriptor the address advances and the remaining length shrinks by the descriptor length, until the segment is used up. Descriptor n occupies table word indices 4n to 4n+3, starting from n = 0 for each list.
- R3: Word 0 and word 2 of a descriptor are zero. Word 1 is the address with its four bytes reversed (address bits 7:0 land in bits 31:24). Word 3 is the 32-bit length value with its bytes reversed in the same way.
- R4: When a list ends with one or more descriptors, the builder writes word index 4(n-1)+3 again, where n is the entry count. The rewritten word is the byte-reversed form of the final length value with bit 31 set, which places the flag at bit 7 of the emitted word. This rewrite is issued the cycle after the last word of the final descriptor is accepted.
- R5: The table holds TABLE_BYTES/64 entries (64 by default). If a list would need one more descriptor than that, no further words are written and no end-of-list rewrite happens. Segments up to the end of the list are accepted and discarded, and `done` reports count 0 with `done_ovf` high.
- R6: A zero-length segment ends the list and adds no descriptor. A list with no descriptors produces no writes and reports count 0 without overflow.
- R7: `done` is high for exactly one cycle, the cycle after the end-of-list rewrite is accepted, and `done_count` carries the entry count during that cycle. The next segment can be accepted afterwards.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_idx` and `wr_data` hold steady. `seg_ready` is never high while a word is offered.
- R9: A synchronous `clr` drops any partial build without a `done` pulse. The next list starts again at table index 0.
- R10: After reset `seg_ready` is high, and `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the build in progress |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Builder accepts a segment |
| seg_addr | input | 32 | Segment start byte address |
| seg_len | input | LEN_W | Segment length in bytes; zero ends the list |
| seg_last | input | 1 | Segment is the last of its list |
| wr_valid | output | 1 | Table word offered |
| wr_ready | input | 1 | Table memory takes the word |
| wr_idx | output | IDX_W | Word index into the table |
| wr_data | output | 32 | Table word |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | CNT_W | Entry count, valid with done |
| done_ovf | output | 1 | List overflowed the table, valid with done |

## Verification
The first word of a segment is offered the cycle after that segment is accepted. After that, words advance one per cycle in which `wr_ready` is high. The end-marker rewrite follows the last length word by one cycle, and `done` follows the accepted rewrite by one cycle. The bench samples every handshake on the falling edge and compares it in order against a behavioural model's queue. It also requires `done` on the falling edge right after the rewrite, and checks that stalled words stay unchanged.

// File: rtl/dtb_pkg.sv
// Package: shared state encoding and word helpers for the descriptor builder.
package dtb_pkg;

    // Builder control states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EMIT  = 3'd1,
        ST_EOL   = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } dtb_state_e;

    // Width of a descriptor length (up to a full 64 KiB span).
    localparam int CHUNK_W = 17;

    // Bit of the length value that flags the final descriptor.
    localparam logic [31:0] EOL_FLAG = 32'h8000_0000;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/dtb_chunker.sv
// Module: dtb_chunker
// Computes the length of the next descriptor: bytes left before the next
// 64 KiB boundary, capped at the remaining segment length.
// Assumes: rem is non-zero whenever the result is used.
module dtb_chunker #(
    parameter int LEN_W = 24
) (
    input  logic [15:0]                 addr_lo,
    input  logic [LEN_W-1:0]            rem,
    output logic [dtb_pkg::CHUNK_W-1:0] chunk
);
    localparam int CW = (LEN_W > dtb_pkg::CHUNK_W) ? LEN_W : dtb_pkg::CHUNK_W;

    logic [dtb_pkg::CHUNK_W-1:0] room;
    logic [CW-1:0]               rem_x;
    logic [CW-1:0]               room_x;

    // Bytes up to the boundary and the capped result.
    always_comb begin
        room   = 17'h10000 - {1'b0, addr_lo};
        rem_x  = CW'(rem);
        room_x = CW'(room);
        chunk  = (rem_x < room_x) ? dtb_pkg::CHUNK_W'(rem_x) : room;
    end
endmodule

// File: rtl/dtb_wordfmt.sv
// Module: dtb_wordfmt
// Selects one of the four words of a descriptor by phase: zero,
// byte-reversed address, zero, byte-reversed length.
// Assumes: phase counts 0..3 within a descriptor.
module dtb_wordfmt (
    input  logic [1:0]                  phase,
    input  logic [31:0]                 addr,
    input  logic [dtb_pkg::CHUNK_W-1:0] chunk,
    output logic [31:0]                 word
);
    // Word multiplexer by phase.
    always_comb begin
        unique case (phase)
            2'd1:    word = dtb_pkg::bswap32(addr);
            2'd3:    word = dtb_pkg::bswap32(32'(chunk));
            default: word = 32'h0;
        endcase
    end
endmodule

// File: rtl/dtb_entry_ctr.sv
// Module: dtb_entry_ctr
// Counts descriptors written in the current list and flags the table limit.
// Assumes: inc is never raised when the count already equals MAX_ENTRIES.
module dtb_entry_ctr #(
    parameter int MAX_ENTRIES = 64,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_max,
    output logic             last_slot
);
    // Entry counter, cleared per list.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || restart)
            count <= '0;
        else if (inc)
            count <= count + CNT_W'(1);
    end

    // Limit flags for the controller.
    always_comb begin
        at_max    = (count == CNT_W'(MAX_ENTRIES));
        last_slot = (count == CNT_W'(MAX_ENTRIES - 1));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count != CNT_W'(MAX_ENTRIES))); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_ENTRIES)); // R5
endmodule

// File: rtl/dtb_builder.sv
// Module: dtb_builder (top)
// Splits incoming segments at 64 KiB boundaries into four-word descriptors,
// writes them by word index, rewrites the final length word with the
// end-of-list flag, and aborts with overflow past the table capacity.
// Assumes: TABLE_BYTES/64 is a power of two of at least 2; LEN_W >= 17.
module dtb_builder #(
    parameter int  TABLE_BYTES = 4096,
    parameter int  LEN_W       = 24,
    localparam int MAX_ENTRIES = TABLE_BYTES / 64,
    localparam int ENT_W       = $clog2(MAX_ENTRIES),
    localparam int CNT_W       = $clog2(MAX_ENTRIES + 1),
    localparam int IDX_W       = ENT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             seg_valid,
    output logic             seg_ready,
    input  logic [31:0]      seg_addr,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_last,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [IDX_W-1:0] wr_idx,
    output logic [31:0]      wr_data,
    output logic             done,
    output logic [CNT_W-1:0] done_count,
    output logic             done_ovf
);
    import dtb_pkg::*;

    dtb_state_e                state;
    logic [1:0]                phase;
    logic [31:0]               cur_addr;
    logic [LEN_W-1:0]          rem;
    logic                      seg_is_last;
    logic                      ovf;
    logic [CHUNK_W-1:0]        eol_len;
    logic [CHUNK_W-1:0]        chunk;
    logic [LEN_W-1:0]          rem_after;
    logic [31:0]               fmt_word;
    logic [CNT_W-1:0]          count;
    logic                      at_max;
    logic                      last_slot;
    logic                      ent_inc;
    logic [ENT_W-1:0]          last_ent;

    dtb_chunker #(.LEN_W(LEN_W)) u_chunker (
        .addr_lo (cur_addr[15:0]),
        .rem     (rem),
        .chunk   (chunk)
    );

    dtb_wordfmt u_fmt (
        .phase (phase),
        .addr  (cur_addr),
        .chunk (chunk),
        .word  (fmt_word)
    );

    dtb_entry_ctr #(.MAX_ENTRIES(MAX_ENTRIES)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .restart   (state == ST_DONE),
        .inc       (ent_inc),
        .count     (count),
        .at_max    (at_max),
        .last_slot (last_slot)
    );

    // Per-descriptor arithmetic and entry bookkeeping.
    always_comb begin
        rem_after = rem - LEN_W'(chunk);
        ent_inc   = (state == ST_EMIT) && (phase == 2'd3) && wr_ready;
        last_ent  = ENT_W'(count - CNT_W'(1));
    end

    // Port outputs derived from the state.
    always_comb begin
        seg_ready  = (state == ST_IDLE) || (state == ST_DRAIN);
        wr_valid   = (state == ST_EMIT) || (state == ST_EOL);
        done       = (state == ST_DONE);
        done_ovf   = (state == ST_DONE) && ovf;
        done_count = ((state == ST_DONE) && !ovf) ? count : '0;
        if (state == ST_EOL) begin
            wr_idx  = {last_ent, 2'b11};
            wr_data = bswap32(32'(eol_len) | EOL_FLAG);
        end else begin
            wr_idx  = {ENT_W'(count), phase};
            wr_data = fmt_word;
        end
    end

    // Control sequencer: accept, emit, mark, drain, report.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state       <= ST_IDLE;
            phase       <= 2'd0;
            cur_addr    <= '0;
            rem         <= '0;
            seg_is_last <= 1'b0;
            ovf         <= 1'b0;
            eol_len     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (seg_valid) begin
                        if (seg_len == '0) begin
                            state <= (count == '0) ? ST_DONE : ST_EOL;
                        end else begin
                            cur_addr    <= seg_addr;
                            rem         <= seg_len;
                            seg_is_last <= seg_last;
                            phase       <= 2'd0;
                            if (at_max) begin
                                ovf   <= 1'b1;
                                state <= seg_last ? ST_DONE : ST_DRAIN;
                            end else begin
                                state <= ST_EMIT;
                            end
                        end
                    end
                end
                ST_EMIT: begin
                    if (wr_ready) begin
                        phase <= phase + 2'd1;
                        if (phase == 2'd3) begin
                            cur_addr <= cur_addr + 32'(chunk);
                            rem      <= rem_after;
                            eol_len  <= chunk;
                            if (rem_after == '0) begin
                                state <= seg_is_last ? ST_EOL : ST_IDLE;
                            end else if (last_slot) begin
                                ovf   <= 1'b1;
                                state <= seg_is_last ? ST_DONE : ST_DRAIN;
                            end
                        end
                    end
                end
                ST_EOL: begin
                    if (wr_ready)
                        state <= ST_DONE;
                end
                ST_DRAIN: begin
                    if (seg_valid && ((seg_len == '0) || seg_last))
                        state <= ST_DONE;
                end
                ST_DONE: begin
                    ovf   <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> ((chunk != '0) &&
        ((18'(cur_addr[15:0]) + 18'(chunk)) <= 18'h10000))); // R1

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_idx))); // R8

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_ready && wr_valid)); // R8

    AST_DONE_AFTER_EOL: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (wr_valid && wr_ready && (wr_idx[1:0] == 2'b11) && wr_data[7]) |=> done); // R4

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ovf) |-> (done_count == '0)); // R5

    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (seg_ready && !wr_valid && !done)); // R9
endmodule

// File: tb/tb_dtb_builder.sv
`timescale 1ns/1ps
module tb_dtb_builder;
    localparam int TABLE_BYTES = 4096;
    localparam int LEN_W       = 24;
    localparam int MAXE        = TABLE_BYTES / 64;
    localparam int CNT_W       = $clog2(MAXE + 1);
    localparam int IDX_W       = $clog2(MAXE) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic seg_valid = 1'b0;
    logic seg_ready;
    logic [31:0] seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic seg_last = 1'b0;
    logic wr_valid;
    logic wr_ready = 1'b1;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0] wr_data;
    logic done;
    logic [CNT_W-1:0] done_count;
    logic done_ovf;

    always #5 clk = ~clk;

    dtb_builder #(.TABLE_BYTES(TABLE_BYTES), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .done_count(done_count), .done_ovf(done_ovf)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit stall   = 1'b0;
    bit finished = 1'b0;

    // Expected write and completion events.
    int          ew_idx[$];
    logic [31:0] ew_dat[$];
    string       ew_tag[$];
    int          ed_cnt[$];
    bit          ed_ovf[$];
    string       ed_tag[$];

    // Segment list of the current test.
    logic [31:0] sq_a[$];
    int          sq_l[$];
    bit          sq_last[$];

    bit          hold_prev = 1'b0;
    logic [31:0] p_dat;
    logic [IDX_W-1:0] p_idx;
    bit          pend_done = 1'b0;

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic add_seg(input logic [31:0] a, input int l, input bit last);
        sq_a.push_back(a);
        sq_l.push_back(l);
        sq_last.push_back(last);
    endtask

    // Behavioural model of one list.
    task automatic model_list(input string tag);
        int cnt = 0;
        bit ov = 1'b0;
        int lastlen = 0;
        foreach (sq_a[i]) begin
            logic [31:0] a;
            int rem;
            if (sq_l[i] == 0) break;
            a = sq_a[i];
            rem = sq_l[i];
            while (rem > 0) begin
                int ch;
                if (cnt == MAXE) begin
                    ov = 1'b1;
                    break;
                end
                ch = 65536 - int'(a[15:0]);
                if (rem < ch) ch = rem;
                ew_idx.push_back(cnt*4);     ew_dat.push_back(32'h0);       ew_tag.push_back(tag);
                ew_idx.push_back(cnt*4 + 1); ew_dat.push_back(rev(a));      ew_tag.push_back(tag);
                ew_idx.push_back(cnt*4 + 2); ew_dat.push_back(32'h0);       ew_tag.push_back(tag);
                ew_idx.push_back(cnt*4 + 3); ew_dat.push_back(rev(32'(ch))); ew_tag.push_back(tag);
                lastlen = ch;
                cnt++;
                a = a + 32'(ch);
                rem = rem - ch;
            end
            if (ov || sq_last[i]) break;
        end
        if (ov) begin
            ed_cnt.push_back(0); ed_ovf.push_back(1'b1); ed_tag.push_back("R5");
        end else if (cnt > 0) begin
            ew_idx.push_back((cnt-1)*4 + 3);
            ew_dat.push_back(rev(32'(lastlen) | 32'h8000_0000));
            ew_tag.push_back("R4");
            ed_cnt.push_back(cnt); ed_ovf.push_back(1'b0); ed_tag.push_back(tag);
        end else begin
            ed_cnt.push_back(0); ed_ovf.push_back(1'b0); ed_tag.push_back("R6");
        end
    endtask

    task automatic send_seg(input logic [31:0] a, input int l, input bit last);
        @(negedge clk);
        seg_valid = 1'b1;
        seg_addr  = a;
        seg_len   = LEN_W'(l);
        seg_last  = last;
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic wait_empty(input string tag);
        int k = 0;
        while ((ew_idx.size() != 0 || ed_cnt.size() != 0) && k < 30000) begin
            @(negedge clk);
            k++;
        end
        chk(ew_idx.size() == 0 && ed_cnt.size() == 0, tag, "all expected events seen",
            32'(ew_idx.size() + ed_cnt.size()), 32'h0);
        @(negedge clk);
    endtask

    task automatic run_list(input string tag);
        model_list(tag);
        foreach (sq_a[i]) send_seg(sq_a[i], sq_l[i], sq_last[i]);
        wait_empty(tag);
        sq_a.delete(); sq_l.delete(); sq_last.delete();
    endtask

    // Per-cycle monitor on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            wr_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (clr) begin
                hold_prev = 1'b0;
                pend_done = 1'b0;
            end else begin
                if (pend_done) begin
                    chk(done == 1'b1, "R7", "done one cycle after end-marker rewrite",
                        32'(done), 32'h1);
                    pend_done = 1'b0;
                end
                if (hold_prev) begin
                    chk(wr_valid && wr_data == p_dat && wr_idx == p_idx, "R8",
                        "stalled word held", wr_data, p_dat);
                end
                if (wr_valid && wr_ready) begin
                    if (ew_idx.size() == 0) begin
                        chk(1'b0, "R3", "unexpected write", wr_data, 32'h0);
                    end else begin
                        string t;
                        t = ew_tag.pop_front();
                        chk(32'(wr_idx) == 32'(ew_idx[0]), t, "word index",
                            32'(wr_idx), 32'(ew_idx[0]));
                        chk(wr_data == ew_dat[0], t, "word data", wr_data, ew_dat[0]);
                        void'(ew_idx.pop_front());
                        void'(ew_dat.pop_front());
                        if (t == "R4") pend_done = 1'b1;
                    end
                end
                if (done) begin
                    if (ed_cnt.size() == 0) begin
                        chk(1'b0, "R7", "unexpected done", 32'(done_count), 32'h0);
                    end else begin
                        string t;
                        t = ed_tag.pop_front();
                        chk(32'(done_count) == 32'(ed_cnt[0]), t, "done count",
                            32'(done_count), 32'(ed_cnt[0]));
                        chk(done_ovf == ed_ovf[0], t, "overflow flag",
                            32'(done_ovf), 32'(ed_ovf[0]));
                        void'(ed_cnt.pop_front());
                        void'(ed_ovf.pop_front());
                    end
                end
                hold_prev = wr_valid && !wr_ready;
                p_dat = wr_data;
                p_idx = wr_idx;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(seg_ready == 1'b1, "R10", "seg_ready in reset", 32'(seg_ready), 32'h1);
        chk(wr_valid == 1'b0 && done == 1'b0, "R10", "no write or done in reset",
            32'({wr_valid, done}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: single small segment, words and byte order
        add_seg(32'h1000_0104, 32'h200, 1'b1);
        run_list("R3");

        // R1: segment crossing a 64 KiB boundary
        add_seg(32'h0001_FF00, 32'h300, 1'b1);
        run_list("R1");

        // R1: start exactly on a boundary and end on the next
        add_seg(32'h0003_0000, 32'h10000, 1'b1);
        run_list("R1");

        // R2: long segment split into several descriptors, with stalls
        stall = 1'b1;
        add_seg(32'h0002_0000, 32'h28000, 1'b1);
        run_list("R2");

        // R6: several segments ended by a zero-length one, stalls kept
        add_seg(32'h4000_FFF0, 32'h20, 1'b0);
        add_seg(32'h5000_0000, 32'h1234, 1'b0);
        add_seg(32'h0, 0, 1'b0);
        run_list("R6");
        stall = 1'b0;

        // R6: empty list
        add_seg(32'h7777_0000, 0, 1'b0);
        run_list("R6");

        // R5: exactly table-full list, no overflow
        add_seg(32'h0, 64 * 32'h10000, 1'b1);
        run_list("R5");

        // R5: overflow inside a segment, trailing segment drained
        add_seg(32'h0, 65 * 32'h10000, 1'b0);
        add_seg(32'h0000_0100, 32'h10, 1'b1);
        run_list("R5");

        // R5: overflow detected when the next segment arrives
        add_seg(32'h0, 64 * 32'h10000, 1'b0);
        add_seg(32'h0000_0200, 32'h20, 1'b1);
        run_list("R5");

        // R7: back-to-back lists after done
        add_seg(32'h0000_8000, 32'h40, 1'b1);
        run_list("R7");

        // R9: clear in the middle of a build
        add_seg(32'h0, 32'h50000, 1'b1);
        model_list("R9");
        send_seg(sq_a[0], sq_l[0], sq_last[0]);
        sq_a.delete(); sq_l.delete(); sq_last.delete();
        repeat (6) @(negedge clk);
        clr = 1'b1;
        ew_idx.delete(); ew_dat.delete(); ew_tag.delete();
        ed_cnt.delete(); ed_ovf.delete(); ed_tag.delete();
        @(negedge clk);
        clr = 1'b0;
        chk(wr_valid == 1'b0 && done == 1'b0, "R9", "build dropped by clear",
            32'({wr_valid, done}), 32'h0);
        chk(seg_ready == 1'b1, "R9", "ready after clear", 32'(seg_ready), 32'h1);
        repeat (3) @(negedge clk);
        // R9: next list starts at index 0
        add_seg(32'h0009_FFFC, 32'h8, 1'b1);
        run_list("R9");

        summary();
    end
endmodule